// File: doc/BRIEF.md
# Interrupt In-Service Priority Tracker

This block records which maskable-interrupt priority levels are being serviced at any moment. It also holds the global flag that blocks maskable interrupts. An acknowledge strobe with a level sets that level's bit in an in-service vector. A return strobe from a maskable handler clears the most urgent bit still set. A return from a non-maskable handler or from an exception leaves the vector alone.

The disable flag is driven by enable and disable instruction strobes, by writes to the status word, and by the status word restored on a return. Any acknowledge forces it to 1. Level 0 is the most urgent level and the last level is the least urgent.

A combinational gate output tells the interrupt controller whether a request at a given level may be acknowledged now. That is true only when the flag is clear and no level of the same or greater urgency is in service. Arbitration across sources, vector generation and saving of the program counter are handled outside this block.

Top module: `isr_level_tracker`

## Requirements
- R1: During and immediately after reset, `insvc` is 0x00 and `dis_flag` is 1, so maskable interrupts start out blocked.
- R2: When `ack_vld` is 1, bit `ack_lvl` of `insvc` is 1 after the next clock edge. Other bits follow only a return in the same cycle.
- R3: A return with `ret_vld`=1 and `ret_nonmask`=0 clears only the lowest-index set bit of `insvc`. When `insvc` is 0x00 it has no effect.
- R4: A return with `ret_nonmask`=1 leaves `insvc` unchanged.
- R5: `insvc` has no software write path. Status-word writes and the enable and disable strobes never change it, and no bit becomes set without an acknowledge.
- R6: `dis_flag` takes its next value from the highest-ranked active source, in this order:
  - `di_stb` sets it to 1;
  - `ei_stb` clears it to 0;
  - `sw_wr` loads bit 5 of `sw_wdata`;
  - `ret_vld` loads bit 5 of `ret_sw`.
  With no active source it holds.
- R7: An acknowledge sets `dis_flag` to 1 after the clock edge. It overrides every source listed in R6.
- R8: `grant_ok` is 1 exactly when `dis_flag` is 0 and no `insvc` bit at index 0 to `req_lvl` (inclusive) is set.
- R9: If an acknowledge and a maskable return fall in the same cycle, the return's clear is applied first and the acknowledge's set second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_vld | input | 1 | Maskable interrupt acknowledged this cycle |
| ack_lvl | input | 3 | Priority level of the acknowledged interrupt |
| ret_vld | input | 1 | Return-from-interrupt strobe |
| ret_nonmask | input | 1 | Return is from a non-maskable interrupt or an exception |
| ret_sw | input | 32 | Status word restored by the return |
| ei_stb | input | 1 | Enable-interrupts instruction strobe |
| di_stb | input | 1 | Disable-interrupts instruction strobe |
| sw_wr | input | 1 | Status-word write strobe |
| sw_wdata | input | 32 | Status-word write data |
| req_lvl | input | 3 | Level of the pending request being gated |
| insvc | output | 8 | Read-only in-service vector, one bit per level |
| dis_flag | output | 1 | Maskable interrupt disable flag |
| grant_ok | output | 1 | Request at `req_lvl` may be acknowledged |

## Verification
The bound checker watches several rules on every cycle:
- an acknowledge leaves its bit set and the flag raised;
- no bit becomes set without an acknowledge;
- a non-maskable return holds the vector;
- a maskable return on a non-empty vector removes exactly one bit;
- the gate stays closed while the flag is set or level 0 is busy.

Other behaviour can only be shown by the directed scenarios:
- which bit a return removes when several levels are nested;
- the ranking among the flag sources;
- the clear-then-set ordering when an acknowledge and a return coincide;
- the exact gate result for each request level against a given vector.

// File: rtl/isp_pkg.sv
package isp_pkg;
   parameter int unsigned ISP_LEVELS  = 8;
   parameter int unsigned ISP_SW_W    = 32;
   parameter int unsigned ISP_DIS_BIT = 5;

   typedef enum logic [2:0] {
      FL_HOLD,
      FL_SET,
      FL_CLR,
      FL_SWW,
      FL_RET
   } fl_src_e;
endpackage

// File: rtl/isp_lowbit.sv
module isp_lowbit #(
   parameter int unsigned N    = 8,
   parameter bit          TWOS = 1'b1
) (
   input  logic [N-1:0] vec,
   output logic [N-1:0] onehot
);
   generate
      if (TWOS) begin : g_twos
         assign onehot = vec & (~vec + N'(1));
      end else begin : g_scan
         always_comb begin
            logic found;
            found  = 1'b0;
            onehot = '0;
            for (int i = 0; i < int'(N); i++) begin
               if (vec[i] && !found) begin
                  onehot[i] = 1'b1;
                  found     = 1'b1;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/isp_insvc_reg.sv
module isp_insvc_reg #(
   parameter int unsigned N  = 8,
   parameter int unsigned LW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_vld,
   input  logic [LW-1:0] set_lvl,
   input  logic          clr_vld,
   input  logic [N-1:0]  clr_mask,
   output logic [N-1:0]  q
);
   logic [N-1:0] after_clr;
   logic [N-1:0] set_mask;
   logic [N-1:0] nxt;

   always_comb begin
      after_clr = clr_vld ? (q & ~clr_mask) : q;
      set_mask  = set_vld ? (N'(1) << set_lvl) : '0;
      nxt       = after_clr | set_mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end
endmodule

// File: rtl/isp_dis_flag.sv
module isp_dis_flag
   import isp_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ack,
   input  logic di,
   input  logic ei,
   input  logic sw_wr,
   input  logic sw_bit,
   input  logic ret,
   input  logic ret_bit,
   output logic q
);
   fl_src_e src;

   always_comb begin
      if      (ack || di) src = FL_SET;
      else if (ei)        src = FL_CLR;
      else if (sw_wr)     src = FL_SWW;
      else if (ret)       src = FL_RET;
      else                src = FL_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= 1'b1;
      end else begin
         case (src)
            FL_SET:  q <= 1'b1;
            FL_CLR:  q <= 1'b0;
            FL_SWW:  q <= sw_bit;
            FL_RET:  q <= ret_bit;
            default: q <= q;
         endcase
      end
   end
endmodule

// File: rtl/isp_ack_gate.sv
module isp_ack_gate #(
   parameter int unsigned N  = 8,
   parameter int unsigned LW = 3
) (
   input  logic [N-1:0]  insvc,
   input  logic          dis,
   input  logic [LW-1:0] req_lvl,
   output logic          ok
);
   logic [N-1:0] covered;

   always_comb begin
      for (int i = 0; i < int'(N); i++) begin
         covered[i] = (LW'(i) <= req_lvl);
      end
      ok = !dis && ((insvc & covered) == '0);
   end
endmodule

// File: rtl/isr_level_tracker.sv
module isr_level_tracker #(
   parameter int unsigned LEVELS    = isp_pkg::ISP_LEVELS,
   parameter int unsigned SW_W      = isp_pkg::ISP_SW_W,
   parameter int unsigned DIS_BIT   = isp_pkg::ISP_DIS_BIT,
   parameter bit          TWOS_SCAN = 1'b1,
   localparam int unsigned LVL_W    = $clog2(LEVELS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ack_vld,
   input  logic [LVL_W-1:0] ack_lvl,
   input  logic             ret_vld,
   input  logic             ret_nonmask,
   input  logic [SW_W-1:0]  ret_sw,
   input  logic             ei_stb,
   input  logic             di_stb,
   input  logic             sw_wr,
   input  logic [SW_W-1:0]  sw_wdata,
   input  logic [LVL_W-1:0] req_lvl,
   output logic [LEVELS-1:0] insvc,
   output logic             dis_flag,
   output logic             grant_ok
);
   generate
      if (LEVELS < 2 || LEVELS > 32) begin : g_bad_levels
         $error("LEVELS must lie in 2..32");
      end
      if ((1 << LVL_W) != LEVELS) begin : g_bad_pow2
         $error("LEVELS must be a power of two");
      end
      if (DIS_BIT >= SW_W) begin : g_bad_bit
         $error("DIS_BIT must index into the status word");
      end
   endgenerate

   logic [LEVELS-1:0] top_bit;
   logic              ret_clr;

   assign ret_clr = ret_vld && !ret_nonmask;

   isp_lowbit #(.N(LEVELS), .TWOS(TWOS_SCAN)) u_low (
      .vec    (insvc),
      .onehot (top_bit)
   );

   isp_insvc_reg #(.N(LEVELS), .LW(LVL_W)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_vld  (ack_vld),
      .set_lvl  (ack_lvl),
      .clr_vld  (ret_clr),
      .clr_mask (top_bit),
      .q        (insvc)
   );

   isp_dis_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .ack     (ack_vld),
      .di      (di_stb),
      .ei      (ei_stb),
      .sw_wr   (sw_wr),
      .sw_bit  (sw_wdata[DIS_BIT]),
      .ret     (ret_vld),
      .ret_bit (ret_sw[DIS_BIT]),
      .q       (dis_flag)
   );

   isp_ack_gate #(.N(LEVELS), .LW(LVL_W)) u_gate (
      .insvc   (insvc),
      .dis     (dis_flag),
      .req_lvl (req_lvl),
      .ok      (grant_ok)
   );
endmodule

// File: rtl/isp_chk.sv
module isp_chk #(
   parameter int unsigned LEVELS = 8,
   parameter int unsigned LVL_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ack_vld,
   input logic [LVL_W-1:0]  ack_lvl,
   input logic              ret_vld,
   input logic              ret_nonmask,
   input logic [LEVELS-1:0] insvc,
   input logic              dis_flag,
   input logic              grant_ok
);
   AST_RESET_STATE: assert property (@(posedge clk)
      !rst_n |=> (insvc == '0 && dis_flag)); // R1

   AST_ACK_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      ack_vld |=> insvc[$past(ack_lvl)]); // R2

   AST_RET_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_vld && !ret_nonmask && !ack_vld && insvc != '0)
      |=> ($countones(insvc) + 1 == $countones($past(insvc)))); // R3

   AST_NONMASK_RET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_vld && ret_nonmask && !ack_vld) |=> $stable(insvc)); // R4

   AST_NO_SET_WITHOUT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_vld |=> ((insvc & ~$past(insvc)) == '0)); // R5

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_vld && !ret_vld) |=> $stable(insvc)); // R5

   AST_ACK_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
      ack_vld |=> dis_flag); // R7

   AST_GATE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      dis_flag |-> !grant_ok); // R8

   AST_GATE_LEVEL0: assert property (@(posedge clk) disable iff (!rst_n)
      insvc[0] |-> !grant_ok); // R8
endmodule

bind isr_level_tracker isp_chk #(.LEVELS(LEVELS), .LVL_W(LVL_W)) u_chk (.*);

// File: tb/sim_isr_level_tracker.sv
module sim_isr_level_tracker;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ack_vld = 1'b0;
   logic [2:0]  ack_lvl = '0;
   logic        ret_vld = 1'b0;
   logic        ret_nonmask = 1'b0;
   logic [31:0] ret_sw = '0;
   logic        ei_stb = 1'b0;
   logic        di_stb = 1'b0;
   logic        sw_wr = 1'b0;
   logic [31:0] sw_wdata = '0;
   logic [2:0]  req_lvl = '0;
   logic [7:0]  insvc;
   logic        dis_flag;
   logic        grant_ok;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   isr_level_tracker u0 (
      .clk(clk), .rst_n(rst_n), .ack_vld(ack_vld), .ack_lvl(ack_lvl),
      .ret_vld(ret_vld), .ret_nonmask(ret_nonmask), .ret_sw(ret_sw),
      .ei_stb(ei_stb), .di_stb(di_stb), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
      .req_lvl(req_lvl), .insvc(insvc), .dis_flag(dis_flag), .grant_ok(grant_ok)
   );

   task automatic chk(input string req, input string what, input logic [31:0] got,
                      input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      ack_vld = 0; ret_vld = 0; ret_nonmask = 0; ei_stb = 0; di_stb = 0; sw_wr = 0;
   endtask

   task automatic gate(input logic [2:0] lvl, input logic exp, input string req);
      req_lvl = lvl;
      #1;
      chk(req, "grant_ok", {31'b0, grant_ok}, {31'b0, exp});
   endtask

   task automatic t_reset();
      chk("R1", "insvc at reset", {24'b0, insvc}, 32'h00);
      chk("R1", "dis_flag at reset", {31'b0, dis_flag}, 1);
      gate(3'd7, 1'b0, "R8");
   endtask

   task automatic t_flag();
      ei_stb = 1; step();
      chk("R6", "ei clears", {31'b0, dis_flag}, 0);
      di_stb = 1; step();
      chk("R6", "di sets", {31'b0, dis_flag}, 1);
      ei_stb = 1; di_stb = 1; step();
      chk("R6", "di outranks ei", {31'b0, dis_flag}, 1);
      ei_stb = 1; step();
      chk("R5", "insvc after ei/di", {24'b0, insvc}, 32'h00);
   endtask

   task automatic t_ack();
      ack_vld = 1; ack_lvl = 3'd5; step();
      chk("R2", "ack 5", {24'b0, insvc}, 32'h20);
      chk("R7", "ack raises flag", {31'b0, dis_flag}, 1);
      ei_stb = 1; step();
      ack_vld = 1; ack_lvl = 3'd2; step();
      chk("R2", "ack 2 nested", {24'b0, insvc}, 32'h24);
      ei_stb = 1; step();
      ack_vld = 1; ack_lvl = 3'd7; ei_stb = 1; step();
      chk("R2", "ack 7 nested", {24'b0, insvc}, 32'hA4);
      chk("R7", "ack outranks ei", {31'b0, dis_flag}, 1);
      ei_stb = 1; step();
   endtask

   task automatic t_gate();
      gate(3'd0, 1'b1, "R8");
      gate(3'd1, 1'b1, "R8");
      gate(3'd2, 1'b0, "R8");
      gate(3'd5, 1'b0, "R8");
      gate(3'd7, 1'b0, "R8");
      di_stb = 1; step();
      gate(3'd0, 1'b0, "R8");
      ei_stb = 1; step();
   endtask

   task automatic t_ret();
      ret_vld = 1; ret_sw = 32'h0; step();
      chk("R3", "ret clears level 2", {24'b0, insvc}, 32'hA0);
      chk("R6", "ret restores 0", {31'b0, dis_flag}, 0);
      ret_vld = 1; ret_nonmask = 1; ret_sw = 32'h20; step();
      chk("R4", "nonmask ret holds", {24'b0, insvc}, 32'hA0);
      chk("R6", "ret restores 1", {31'b0, dis_flag}, 1);
      ret_sw = 32'h0;
      ei_stb = 1; step();
   endtask

   task automatic t_sw();
      sw_wr = 1; sw_wdata = 32'hFFFF_FFFF; step();
      chk("R6", "sw write bit5=1", {31'b0, dis_flag}, 1);
      chk("R5", "sw write ignores insvc", {24'b0, insvc}, 32'hA0);
      sw_wr = 1; sw_wdata = 32'hFFFF_FFDF; step();
      chk("R6", "sw write bit5=0", {31'b0, dis_flag}, 0);
      sw_wr = 1; sw_wdata = 32'h20; ei_stb = 1; step();
      chk("R6", "ei outranks sw write", {31'b0, dis_flag}, 0);
      sw_wr = 1; sw_wdata = 32'h20; ret_vld = 1; ret_nonmask = 1; step();
      chk("R6", "sw write outranks ret", {31'b0, dis_flag}, 1);
      ei_stb = 1; step();
   endtask

   task automatic t_same();
      ack_vld = 1; ack_lvl = 3'd5; ret_vld = 1; step();
      chk("R9", "ack+ret same level", {24'b0, insvc}, 32'hA0);
      chk("R7", "ack outranks ret", {31'b0, dis_flag}, 1);
      ack_vld = 1; ack_lvl = 3'd3; ret_vld = 1; step();
      chk("R9", "ack 3 + ret", {24'b0, insvc}, 32'h88);
   endtask

   task automatic t_drain();
      ret_vld = 1; step();
      chk("R3", "ret clears 3", {24'b0, insvc}, 32'h80);
      ret_vld = 1; step();
      chk("R3", "ret clears 7", {24'b0, insvc}, 32'h00);
      ret_vld = 1; step();
      chk("R3", "ret on empty", {24'b0, insvc}, 32'h00);
      gate(3'd7, 1'b1, "R8");
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_flag();
      t_ack();
      t_gate();
      t_ret();
      t_sw();
      t_same();
      t_drain();
      if (!done) begin
         done = 1'b1;
         summary();
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule